// File: doc/BRIEF.md
# Sampling Phase Window Search Engine

This block finds a good sampling phase for a fast card link. After a start strobe it sweeps a delay line's phase select from zero up to a calibrated maximum, always with the same calibrated delay unit. For every trial phase it programs the delay line, asks an external command engine for one tuning-pattern transfer, and waits for a pass or fail answer. A missing answer counts as a fail.

The engine keeps track of the current run of consecutive passing phases and of the longest such run, together with the phase where that run ended. When the sweep is over, it takes the centre of the longest run and programs it into the delay line. If no phase passed, it reports that no working window exists. Separately, any rewrite of the link's power configuration forces the delay line's control register to zero, so the output clock follows the input clock without delay.

The delay line is reached through one write port with a one-bit register select. The control register (select 0) has a delay-enable bit at bit 0 and a sampler-enable bit at bit 1. The configuration register (select 1) takes the phase select at bits 3:0 and the delay unit at bits 14:8.

Top module: `phase_window_search`

## Requirements
- R1: After reset the block is idle. busy, done, noWindow, tuneReq and regWrEn are 0 and chosenPhase is 0.
- R2: A startReq seen while idle latches calUnit and calMaxPhase and starts a sweep. The sweep tries phases 0, 1, … up to the latched maximum inclusive, in ascending order, with exactly one tuneReq pulse per phase. Later changes on calUnit or calMaxPhase have no effect on that sweep.
- R3: Every trial phase is programmed by three writes in this order: control register (select 0) with data 3 (both enables), configuration register (select 1) with the latched unit at bits 14:8 and the trial phase at bits 3:0, then control register with data 1 (delay enable only, sampler off). tuneReq follows in the cycle right after the third write.
- R4: The engine waits for tuneDone and takes tunePass with it. If no tuneDone arrives within TIMEOUT_CYC cycles, the trial counts as a fail. A tuneDone arriving outside the waiting window is ignored.
- R5: A fail sets the current run length to zero. A pass increments it. Only a run length strictly greater than the best so far replaces the best, and it records the current phase as the window end, so among equal runs the earliest one wins.
- R6: With a nonzero best run, the final phase is the window end minus half the best length, rounded down. It is programmed with the same three writes as R3 and shown on chosenPhase. One cycle after the last of those writes, done pulses for one cycle with noWindow at 0.
- R7: If no phase passed, done pulses for one cycle together with noWindow at 1 and no final writes are issued.
- R8: In every cycle with pwrCfgWrite high, the write port carries a control register write of value 0. Any sweep write due in that cycle is held and issued in a later cycle, so none is lost.
- R9: startReq while a sweep is running is ignored: no second sweep and no extra trials.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start a sweep (honoured only when idle) |
| calUnit | input | UNIT_W | Calibrated delay unit |
| calMaxPhase | input | SEL_W | Calibrated highest phase to try |
| pwrCfgWrite | input | 1 | Power configuration is being rewritten |
| tuneReq | output | 1 | One-cycle request for a tuning transfer |
| tuneDone | input | 1 | Tuning transfer completed |
| tunePass | input | 1 | Result of the completed transfer, 1 = pass |
| regWrEn | output | 1 | Delay line register write strobe |
| regWrAddr | output | 1 | 0 = control register, 1 = configuration register |
| regWrData | output | DATA_W | Write data |
| chosenPhase | output | SEL_W | Phase selected by the last successful sweep |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| noWindow | output | 1 | With done: no phase passed |

## Verification
The write port is shared by two functions. In the same cycle, the power-configuration clear can fall on one of the sweep's programming writes. The bench raises pwrCfgWrite at random cycles during sweeps, so it lands on control writes, configuration writes, final writes and waiting cycles alike. Each such cycle is judged on its own as a zero control write. All other writes are logged and compared one for one with the full expected per-phase sequence, so a sweep write that was dropped, duplicated or reordered behind the clear shows up as a sequence mismatch.

// File: rtl/phase_search_pkg.sv
package phase_search_pkg;

  // Kind of delay line write requested by the control FSM
  typedef enum logic [1:0] {
    WR_NONE,
    WR_CTRL_BOTH,
    WR_CFG,
    WR_CTRL_DLY
  } wrKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic sweepInit;  // latch calibration, clear run tracking, phase = 0
    logic phaseStep;  // advance to next trial phase
    logic trialPass;  // current trial passed
    logic trialFail;  // current trial failed or timed out
    logic waitTick;   // count one more waiting cycle
    logic loadFinal;  // capture centre phase into chosen register
    logic cfgFinal;   // configuration write carries the chosen phase
  } ctlStrobe_t;

  // Register select values and field positions seen by the delay line
  localparam logic CTRL_ADDR    = 1'b0;
  localparam logic CFG_ADDR     = 1'b1;
  localparam int   CTRL_DLY_BIT = 0;
  localparam int   CTRL_SMP_BIT = 1;
  localparam int   CFG_SEL_LSB  = 0;
  localparam int   CFG_UNIT_LSB = 8;

endpackage

// File: rtl/phase_search_dp.sv
module phase_search_dp
  import phase_search_pkg::*;
#(
  parameter int SEL_W       = 4,
  parameter int UNIT_W      = 7,
  parameter int DATA_W      = 32,
  parameter int TIMEOUT_CYC = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  wrKind_e           wrKind,
  input  logic              pwrCfgWrite,
  input  logic [UNIT_W-1:0] calUnit,
  input  logic [SEL_W-1:0]  calMaxPhase,
  output logic              lastPhase,
  output logic              timedOut,
  output logic              bestZero,
  output logic [SEL_W-1:0]  chosenPhase,
  output logic              regWrEn,
  output logic              regWrAddr,
  output logic [DATA_W-1:0] regWrData
);

  localparam int LEN_W  = SEL_W + 1;
  localparam int WAIT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(TIMEOUT_CYC - 1);

  logic [UNIT_W-1:0] unitQ;
  logic [SEL_W-1:0]  maxQ;
  logic [SEL_W-1:0]  trialPhase;
  logic [LEN_W-1:0]  curLen;
  logic [LEN_W-1:0]  bestLen;
  logic [SEL_W-1:0]  bestEnd;
  logic [SEL_W-1:0]  chosenQ;
  logic [WAIT_W-1:0] waitCnt;

  logic [LEN_W-1:0]  runNext;
  logic [SEL_W-1:0]  centrePhase;
  logic [SEL_W-1:0]  selVal;

  assign runNext     = curLen + LEN_W'(1);
  // window end minus half the window length, rounded down
  assign centrePhase = bestEnd - bestLen[LEN_W-1:1];

  // calibration latch and trial phase counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      unitQ      <= '0;
      maxQ       <= '0;
      trialPhase <= '0;
    end else if (ctl.sweepInit) begin
      unitQ      <= calUnit;
      maxQ       <= calMaxPhase;
      trialPhase <= '0;
    end else if (ctl.phaseStep) begin
      trialPhase <= trialPhase + SEL_W'(1);
    end
  end

  // run tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLen  <= '0;
      bestLen <= '0;
      bestEnd <= '0;
    end else if (ctl.sweepInit) begin
      curLen  <= '0;
      bestLen <= '0;
      bestEnd <= '0;
    end else if (ctl.trialFail) begin
      curLen <= '0;
    end else if (ctl.trialPass) begin
      curLen <= runNext;
      if (runNext > bestLen) begin
        bestLen <= runNext;
        bestEnd <= trialPhase;
      end
    end
  end

  // response wait counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (ctl.waitTick) begin
      waitCnt <= waitCnt + WAIT_W'(1);
    end else begin
      waitCnt <= '0;
    end
  end

  // chosen phase register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chosenQ <= '0;
    end else if (ctl.loadFinal) begin
      chosenQ <= centrePhase;
    end
  end

  assign lastPhase   = (trialPhase == maxQ);
  assign timedOut    = (waitCnt == WAIT_LAST);
  assign bestZero    = (bestLen == '0);
  assign chosenPhase = chosenQ;
  assign selVal      = ctl.cfgFinal ? chosenQ : trialPhase;

  // write port: power clear wins over any sweep write
  always_comb begin
    regWrEn   = 1'b0;
    regWrAddr = CTRL_ADDR;
    regWrData = '0;
    if (pwrCfgWrite) begin
      regWrEn = 1'b1;
    end else begin
      unique case (wrKind)
        WR_CTRL_BOTH: begin
          regWrEn                 = 1'b1;
          regWrData[CTRL_DLY_BIT] = 1'b1;
          regWrData[CTRL_SMP_BIT] = 1'b1;
        end
        WR_CFG: begin
          regWrEn                              = 1'b1;
          regWrAddr                            = CFG_ADDR;
          regWrData[CFG_SEL_LSB +: SEL_W]      = selVal;
          regWrData[CFG_UNIT_LSB +: UNIT_W]    = unitQ;
        end
        WR_CTRL_DLY: begin
          regWrEn                 = 1'b1;
          regWrData[CTRL_DLY_BIT] = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/phase_search_ctl.sv
module phase_search_ctl
  import phase_search_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       pwrCfgWrite,
  input  logic       tuneDone,
  input  logic       tunePass,
  input  logic       lastPhase,
  input  logic       timedOut,
  input  logic       bestZero,
  output ctlStrobe_t ctl,
  output wrKind_e    wrKind,
  output logic       tuneReq,
  output logic       busy,
  output logic       done,
  output logic       noWindow
);

  typedef enum logic [3:0] {
    S_IDLE,
    S_ON,
    S_CFG,
    S_DLY,
    S_REQ,
    S_WAIT,
    S_EVAL,
    S_FON,
    S_FCFG,
    S_FDLY
  } state_e;

  state_e stateQ, stateD;
  logic   grant;
  logic   finishOk, finishNone;
  logic   doneQ, noWinQ;

  assign grant = !pwrCfgWrite;

  always_comb begin
    stateD     = stateQ;
    ctl        = '0;
    wrKind     = WR_NONE;
    tuneReq    = 1'b0;
    finishOk   = 1'b0;
    finishNone = 1'b0;
    unique case (stateQ)
      S_IDLE: begin
        if (startReq) begin
          ctl.sweepInit = 1'b1;
          stateD        = S_ON;
        end
      end
      S_ON: begin
        wrKind = WR_CTRL_BOTH;
        if (grant) stateD = S_CFG;
      end
      S_CFG: begin
        wrKind = WR_CFG;
        if (grant) stateD = S_DLY;
      end
      S_DLY: begin
        wrKind = WR_CTRL_DLY;
        if (grant) stateD = S_REQ;
      end
      S_REQ: begin
        tuneReq = 1'b1;
        stateD  = S_WAIT;
      end
      S_WAIT: begin
        if (tuneDone) begin
          ctl.trialPass = tunePass;
          ctl.trialFail = !tunePass;
          stateD        = S_EVAL;
        end else if (timedOut) begin
          ctl.trialFail = 1'b1;
          stateD        = S_EVAL;
        end else begin
          ctl.waitTick = 1'b1;
        end
      end
      S_EVAL: begin
        if (!lastPhase) begin
          ctl.phaseStep = 1'b1;
          stateD        = S_ON;
        end else if (bestZero) begin
          finishNone = 1'b1;
          stateD     = S_IDLE;
        end else begin
          ctl.loadFinal = 1'b1;
          stateD        = S_FON;
        end
      end
      S_FON: begin
        wrKind = WR_CTRL_BOTH;
        if (grant) stateD = S_FCFG;
      end
      S_FCFG: begin
        wrKind       = WR_CFG;
        ctl.cfgFinal = 1'b1;
        if (grant) stateD = S_FDLY;
      end
      S_FDLY: begin
        wrKind = WR_CTRL_DLY;
        if (grant) begin
          finishOk = 1'b1;
          stateD   = S_IDLE;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      doneQ  <= 1'b0;
      noWinQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= finishOk | finishNone;
      noWinQ <= finishNone;
    end
  end

  assign busy     = (stateQ != S_IDLE);
  assign done     = doneQ;
  assign noWindow = noWinQ;

endmodule

// File: rtl/phase_window_search.sv
module phase_window_search
  import phase_search_pkg::*;
#(
  parameter int SEL_W       = 4,
  parameter int UNIT_W      = 7,
  parameter int DATA_W      = 32,
  parameter int TIMEOUT_CYC = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [UNIT_W-1:0] calUnit,
  input  logic [SEL_W-1:0]  calMaxPhase,
  input  logic              pwrCfgWrite,
  output logic              tuneReq,
  input  logic              tuneDone,
  input  logic              tunePass,
  output logic              regWrEn,
  output logic              regWrAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic [SEL_W-1:0]  chosenPhase,
  output logic              busy,
  output logic              done,
  output logic              noWindow
);

  ctlStrobe_t ctl;
  wrKind_e    wrKind;
  logic       lastPhase;
  logic       timedOut;
  logic       bestZero;

  phase_search_ctl ctl_i (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .pwrCfgWrite (pwrCfgWrite),
    .tuneDone    (tuneDone),
    .tunePass    (tunePass),
    .lastPhase   (lastPhase),
    .timedOut    (timedOut),
    .bestZero    (bestZero),
    .ctl         (ctl),
    .wrKind      (wrKind),
    .tuneReq     (tuneReq),
    .busy        (busy),
    .done        (done),
    .noWindow    (noWindow)
  );

  phase_search_dp #(
    .SEL_W       (SEL_W),
    .UNIT_W      (UNIT_W),
    .DATA_W      (DATA_W),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .wrKind      (wrKind),
    .pwrCfgWrite (pwrCfgWrite),
    .calUnit     (calUnit),
    .calMaxPhase (calMaxPhase),
    .lastPhase   (lastPhase),
    .timedOut    (timedOut),
    .bestZero    (bestZero),
    .chosenPhase (chosenPhase),
    .regWrEn     (regWrEn),
    .regWrAddr   (regWrAddr),
    .regWrData   (regWrData)
  );

endmodule

// File: rtl/phase_window_search_chk.sv
module phase_window_search_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              pwrCfgWrite,
  input logic              tuneReq,
  input logic              regWrEn,
  input logic              regWrAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              busy,
  input logic              done,
  input logic              noWindow
);

  localparam logic [DATA_W-1:0] DLY_ONLY = DATA_W'(1);

  // R3
  req_after_dly_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    tuneReq |-> $past(regWrEn && !regWrAddr && regWrData == DLY_ONLY));

  // R4
  req_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    tuneReq |=> !tuneReq);

  // R8
  pwr_clear_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrCfgWrite |-> (regWrEn && !regWrAddr && regWrData == '0));

  // R2
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));

  // R6
  done_after_final_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !noWindow) |-> $past(regWrEn && !regWrAddr && regWrData == DLY_ONLY));

  // R6
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R7
  nowin_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    noWindow |-> done);

endmodule

bind phase_window_search phase_window_search_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .startReq    (startReq),
  .pwrCfgWrite (pwrCfgWrite),
  .tuneReq     (tuneReq),
  .regWrEn     (regWrEn),
  .regWrAddr   (regWrAddr),
  .regWrData   (regWrData),
  .busy        (busy),
  .done        (done),
  .noWindow    (noWindow)
);

// File: tb/phase_window_search_tb_top.sv
module phase_window_search_tb_top;

  localparam int SEL_W  = 4;
  localparam int UNIT_W = 7;
  localparam int DATA_W = 32;
  localparam int TO     = 32;

  // trial modes
  localparam int M_PASS = 0;
  localparam int M_FAIL = 1;
  localparam int M_TOUT = 2;
  localparam int M_LATE = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startReq = 1'b0;
  logic [UNIT_W-1:0] calUnit = '0;
  logic [SEL_W-1:0]  calMaxPhase = '0;
  logic              pwrCfgWrite = 1'b0;
  logic              tuneReq;
  logic              tuneDone = 1'b0;
  logic              tunePass = 1'b1;
  logic              regWrEn;
  logic              regWrAddr;
  logic [DATA_W-1:0] regWrData;
  logic [SEL_W-1:0]  chosenPhase;
  logic              busy;
  logic              done;
  logic              noWindow;

  phase_window_search #(
    .SEL_W(SEL_W), .UNIT_W(UNIT_W), .DATA_W(DATA_W), .TIMEOUT_CYC(TO)
  ) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .calUnit(calUnit),
    .calMaxPhase(calMaxPhase), .pwrCfgWrite(pwrCfgWrite), .tuneReq(tuneReq),
    .tuneDone(tuneDone), .tunePass(tunePass), .regWrEn(regWrEn),
    .regWrAddr(regWrAddr), .regWrData(regWrData), .chosenPhase(chosenPhase),
    .busy(busy), .done(done), .noWindow(noWindow)
  );

  always #10 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;

  int mode [16];
  int respIdx = 0;
  int wrCnt = 0, reqCnt = 0, doneCnt = 0;
  logic        logA [128];
  logic [31:0] logD [128];
  logic        expA [64];
  logic [31:0] expD [64];
  logic        gotNoWin;
  int          gotChosen;
  bit          pwrEn = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected window from requirements R5/R6
  function automatic void calcExpect(input int mx, output int best, output int endp,
                                     output int fin);
    int cur = 0;
    best = 0; endp = 0;
    for (int p = 0; p <= mx; p++) begin
      if (mode[p] == M_PASS) begin
        cur++;
        if (cur > best) begin best = cur; endp = p; end
      end else cur = 0;
    end
    fin = endp - best / 2;
  endfunction

  // monitor: sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (pwrCfgWrite) begin
        chk(regWrEn && !regWrAddr && regWrData == 0, "R8 power clear write",
            int'(regWrData) + (regWrEn ? 0 : 1000), 0);
      end else if (regWrEn) begin
        if (wrCnt < 128) begin
          logA[wrCnt] = regWrAddr;
          logD[wrCnt] = regWrData;
        end
        wrCnt++;
      end
      if (tuneReq) reqCnt++;
      if (done) begin
        doneCnt++;
        gotNoWin  = noWindow;
        gotChosen = int'(chosenPhase);
      end
    end
  end

  // tuning responder
  always begin
    @(negedge clk);
    if (rstN && tuneReq) begin
      int m;
      int d;
      m = mode[respIdx];
      respIdx++;
      if (m == M_PASS || m == M_FAIL) begin
        d = int'($urandom % 5);
        repeat (d + 1) @(posedge clk);
        #2 tuneDone = 1'b1; tunePass = (m == M_PASS);
        @(posedge clk);
        #2 tuneDone = 1'b0; tunePass = 1'b1;
      end else if (m == M_LATE) begin
        repeat (TO + 2) @(posedge clk);
        #2 tuneDone = 1'b1; tunePass = 1'b1;
        @(posedge clk);
        #2 tuneDone = 1'b0;
      end
    end
  end

  // random power configuration rewrites
  always begin
    @(posedge clk);
    #2 pwrCfgWrite = pwrEn && ($urandom % 6 == 0);
  end

  task automatic runSweep(input int mx, input int unit, input bit pwrOn,
                          input bit restart, input string tag);
    int best, endp, fin, nExp, guard, firstBad;
    bit anyTimeout;
    calcExpect(mx, best, endp, fin);
    anyTimeout = 0;
    for (int p = 0; p <= mx; p++)
      if (mode[p] == M_TOUT || mode[p] == M_LATE) anyTimeout = 1;
    nExp = 0;
    for (int p = 0; p <= mx + (best > 0 ? 1 : 0); p++) begin
      int ph;
      ph = (p > mx) ? fin : p;
      expA[nExp] = 1'b0; expD[nExp] = 32'd3; nExp++;
      expA[nExp] = 1'b1; expD[nExp] = (32'(unit) << 8) | 32'(ph); nExp++;
      expA[nExp] = 1'b0; expD[nExp] = 32'd1; nExp++;
    end
    respIdx = 0; wrCnt = 0; reqCnt = 0; doneCnt = 0;
    calMaxPhase = SEL_W'(mx);
    calUnit     = UNIT_W'(unit);
    pwrEn       = pwrOn;
    @(posedge clk); #2 startReq = 1'b1;
    @(posedge clk); #2 startReq = 1'b0;
    calUnit     = UNIT_W'($urandom);   // R2: ignored after start
    calMaxPhase = SEL_W'($urandom);
    if (restart) begin
      repeat (6) @(posedge clk);
      #2 startReq = 1'b1;
      @(posedge clk); #2 startReq = 1'b0;
    end
    guard = 0;
    while (doneCnt == 0 && guard < 4000) begin
      @(posedge clk); guard++;
    end
    pwrEn = 0;
    repeat (TO + 12) @(posedge clk);
    // R3 write sequence
    firstBad = -1;
    for (int i = 0; i < nExp && i < wrCnt; i++)
      if (firstBad < 0 && (logA[i] != expA[i] || logD[i] != expD[i])) firstBad = i;
    chk(wrCnt == nExp, {"R3 write count ", tag}, wrCnt, nExp);
    chk(firstBad < 0, {"R3 write order/content ", tag},
        firstBad < 0 ? 0 : int'(logD[firstBad]), firstBad < 0 ? 0 : int'(expD[firstBad]));
    chk(reqCnt == mx + 1, {"R2 trial count ", tag}, reqCnt, mx + 1);
    if (restart) chk(reqCnt == mx + 1 && doneCnt == 1, {"R9 restart ignored ", tag}, reqCnt, mx + 1);
    if (best > 0) begin
      chk(doneCnt == 1, {"R6 done pulses ", tag}, doneCnt, 1);
      chk(gotChosen == fin && gotNoWin == 1'b0, {"R6 chosen phase ", tag}, gotChosen, fin);
      if (anyTimeout) chk(gotChosen == fin, {"R4 timeout as fail ", tag}, gotChosen, fin);
    end else begin
      chk(doneCnt == 1, {"R7 done pulses ", tag}, doneCnt, 1);
      chk(gotNoWin == 1'b1, {"R7 no window flag ", tag}, int'(gotNoWin), 1);
    end
  endtask

  function automatic void setModes(input int a[16]);
    for (int i = 0; i < 16; i++) mode[i] = a[i];
  endfunction

  initial begin
    void'($urandom(32'd20817));
    for (int i = 0; i < 16; i++) mode[i] = M_FAIL;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(!busy && !done && !noWindow, "R1 idle flags", int'({busy, done, noWindow}), 0);
    chk(!regWrEn && !tuneReq, "R1 no write/request", int'({regWrEn, tuneReq}), 0);
    chk(chosenPhase == 0, "R1 chosen phase", int'(chosenPhase), 0);
    // R8 in idle
    @(posedge clk); #2 pwrCfgWrite = 1'b1;
    @(posedge clk); #2 pwrCfgWrite = 1'b0;
    @(posedge clk);

    // R6: all pass, full range
    for (int i = 0; i < 16; i++) mode[i] = M_PASS;
    runSweep(15, 5, 0, 0, "all pass");
    // R7: all fail
    for (int i = 0; i < 16; i++) mode[i] = M_FAIL;
    runSweep(7, 100, 0, 0, "all fail");
    // single phase cases
    mode[0] = M_PASS; runSweep(0, 127, 0, 0, "single pass");
    mode[0] = M_FAIL; runSweep(0, 0, 0, 0, "single fail");
    // R5: equal runs keep the earliest
    setModes('{0,0,1,0,0,1,1,1,1,1,1,1,1,1,1,1});
    runSweep(9, 33, 0, 0, "R5 tie earliest");
    setModes('{0,1,0,0,0,1,0,0,1,1,1,1,1,1,1,1});
    runSweep(8, 12, 0, 0, "R5 longer later");
    // R4: timeouts and late answers
    setModes('{0,2,0,0,3,0,1,1,1,1,1,1,1,1,1,1});
    runSweep(5, 77, 0, 0, "R4 timeout/late");
    setModes('{2,2,3,2,1,1,1,1,1,1,1,1,1,1,1,1});
    runSweep(3, 9, 0, 0, "R4 all silent");
    // window reaching the top phase
    setModes('{1,1,1,0,0,0,0,1,1,1,1,1,1,1,1,1});
    runSweep(6, 64, 1, 0, "window at top");
    // R9 restart and R8 under load
    for (int i = 0; i < 16; i++) mode[i] = M_PASS;
    mode[3] = M_FAIL;
    runSweep(12, 21, 1, 1, "R9 restart");

    // constrained random sweeps
    for (int s = 0; s < 24; s++) begin
      int mx;
      int r;
      mx = int'($urandom % 16);
      for (int i = 0; i < 16; i++) begin
        r = int'($urandom % 16);
        mode[i] = (r < 9) ? M_PASS : (r < 14) ? M_FAIL : (r == 14) ? M_TOUT : M_LATE;
      end
      runSweep(mx, int'($urandom % 128), ($urandom % 2) == 1,
               (mx >= 2) && ($urandom % 3 == 0), "random");
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule